// File: doc/BRIEF.md
# Load Queue Same-Line Ordering Guard

This block keeps in-flight loads in program order in a small circular queue and stops two loads to the same cache line from being seen out of order when another agent writes that line. Loads enter at the tail in program order. Each one later reports the address it was sent to memory with. Then its memory response arrives, which may carry an invalidate. External invalidate snoops are broadcast by line address. Only the oldest entry leaves the queue, and only once it is clean.

When an older load learns its address after a younger load to the same line has already gone to memory, the younger load is marked as a possible ordering hazard. When such a load also sees an invalidate, it is given a pending re-execute fault. The invalidate may come from a snoop, or from the invalidate part of a combined read response. One cycle later the block raises a squash naming the oldest faulting entry, drops that entry and every younger one, and rewinds the tail. A later data response never clears a pending fault and never reports a clean writeback for a faulted load.

Allocation and retirement are valid/ready handshakes. An allocation takes effect on a clock edge where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` falls while the queue is full or while a squash is being raised. A retirement takes effect on an edge where `retire_valid` and `retire_ready` are both high, and the consumer may hold `retire_ready` low for as long as it needs. Address-resolve, response and snoop inputs have no back-pressure and are taken in the cycle they are valid. `DEPTH` must be a power of two.

Top module: `lq_snoop_order`

## Requirements
- R1: `alloc_idx` always names the tail slot, and successive allocations take consecutive slots that wrap from DEPTH-1 to 0. `alloc_ready` is low while DEPTH entries are held or while `squash_valid` is high.
- R2: All address comparisons use whole lines. The address bits below log2(LINE_BYTES), which is 6 bits for 64-byte lines, are ignored, so 0x3000 and 0x3040 are different lines.
- R3: When an entry's address resolves, every younger entry whose address is already resolved and falls in the same line is marked as a possible ordering hazard.
- R4: A snoop on the line of an entry with a resolved address sets that entry's snoop-hit mark. If the entry is also a possible hazard, it becomes faulted. A snoop on an entry that is not a possible hazard causes no squash.
- R5: A response with `resp_inval`=1 acts as a snoop on the entry it targets.
- R6: If an older entry resolves to the line of a younger entry that already has its snoop-hit mark, the younger entry becomes faulted.
- R7: A response produces no clean writeback if its entry is already faulted, becomes faulted in the same cycle, or is being dropped by a squash.
- R8: One cycle after an entry becomes faulted, `squash_valid` is high for one cycle and `squash_idx` names the oldest faulted entry. That entry and all younger ones are dropped, and the next `alloc_idx` equals the squashed index.
- R9: `retire_valid` is high only when the head entry has its data and no fault, and `retire_idx` names the head. A handshake removes that entry.
- R10: When a snoop and a response reach one entry in the same cycle, the snoop is applied first, and the response sees the updated marks.
- R11: A clean response gives `wb_valid`=1 with `wb_idx` equal to the response index in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to enter a new load at the tail |
| alloc_ready | output | 1 | Tail slot can be taken this cycle |
| alloc_idx | output | log2(DEPTH) | Slot that the next allocation takes |
| resolve_valid | input | 1 | A load's address is known and it is sent to memory |
| resolve_idx | input | log2(DEPTH) | Slot whose address resolves |
| resolve_addr | input | ADDR_W | Byte address of that load |
| resp_valid | input | 1 | Memory data response arrives |
| resp_idx | input | log2(DEPTH) | Slot receiving the response |
| resp_inval | input | 1 | Response also carries an invalidate of its line |
| snoop_valid | input | 1 | External invalidate snoop |
| snoop_addr | input | ADDR_W | Address of the invalidated line |
| retire_valid | output | 1 | Head entry may leave |
| retire_ready | input | 1 | Consumer accepts the head entry |
| retire_idx | output | log2(DEPTH) | Slot of the head entry |
| squash_valid | output | 1 | Re-execute request from the named entry onward |
| squash_idx | output | log2(DEPTH) | Oldest faulted slot |
| wb_valid | output | 1 | A load completed cleanly last cycle |
| wb_idx | output | log2(DEPTH) | Slot of that load |

## Verification
A hazard mark that is lost or never set shows up one cycle after the triggering event. The port then shows either a missing squash or a squash with no cause, so the bench checks `squash_valid` in exactly that cycle after every resolve, snoop and response. A wrong choice of oldest faulted entry, or a wrong tail rewind, shows in the same squash cycle on `squash_idx` and in the next cycle on `alloc_idx`. A fault discarded by a late response shows as a spurious `wb_valid` one cycle after that response. Head and count errors show on `retire_valid`, `retire_idx` and `alloc_ready` when the queue is full and when the head index wraps.

// File: rtl/lq_pkg.sv
package lq_pkg;
  // Per-slot state marks
  typedef struct packed {
    logic valid;      // slot holds a load
    logic known;      // address resolved, load sent to memory
    logic done;       // data returned
    logic poss;       // possible ordering hazard
    logic snoop_hit;  // line invalidated while in flight
    logic fault;      // pending re-execute
  } lq_flags_t;
endpackage

// File: rtl/lq_entry.sv
module lq_entry
  import lq_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic              drop_en,
  input  logic              snoop_valid,
  input  logic [LINE_W-1:0] snoop_line,
  input  logic              resp_en,
  input  logic              resp_inval,
  input  logic              resolve_en,
  input  logic              older_resolve,
  input  logic [LINE_W-1:0] resolve_line,
  output logic              valid_o,
  output logic              done_o,
  output logic              fault_o,
  output logic              wb_clean_o
);
  lq_flags_t         f_q, f_n;
  logic [LINE_W-1:0] line_q;
  logic              hit_snoop, hit_resp, hit_order;

  always_comb begin
    hit_snoop = snoop_valid && f_q.valid && f_q.known && (line_q == snoop_line);
    hit_resp  = resp_en && resp_inval && f_q.valid && f_q.known;
    hit_order = older_resolve && f_q.valid && f_q.known && (line_q == resolve_line);
    f_n = f_q;
    if (f_q.valid) begin
      // snoop first, then the invalidate half of a response, then ordering
      f_n.snoop_hit = f_q.snoop_hit | hit_snoop | hit_resp;
      f_n.poss      = f_q.poss | hit_order;
      f_n.fault     = f_q.fault | (f_n.poss & f_n.snoop_hit);
      if (resp_en && f_q.known) f_n.done = 1'b1;
      if (resolve_en && !f_q.known) f_n.known = 1'b1;
    end
    wb_clean_o = resp_en && f_q.valid && f_q.known && !f_n.fault && !drop_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_q    <= '0;
      line_q <= '0;
    end else if (drop_en) begin
      f_q <= '0;
    end else if (alloc_en) begin
      f_q <= '{valid: 1'b1, default: 1'b0};
    end else begin
      f_q <= f_n;
      if (resolve_en && f_q.valid && !f_q.known) line_q <= resolve_line;
    end
  end

  assign valid_o = f_q.valid;
  assign done_o  = f_q.done;
  assign fault_o = f_q.fault;

  // A fault stays until the slot is dropped (R7)
  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (f_q.fault && !drop_en) |=> f_q.fault);
  // A clean writeback never comes from a faulted slot (R7)
  assert_wb_not_faulted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_clean_o |-> !f_q.fault);
  // Allocation only lands on a free slot (R1)
  assert_alloc_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !f_q.valid);
  // A hazard mark exists only on an issued load (R3)
  assert_poss_issued_R3: assert property (@(posedge clk) disable iff (!rst_n)
    f_q.poss |-> f_q.known);
endmodule

// File: rtl/lq_oldest_pick.sv
module lq_oldest_pick #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] mask,
  input  logic [IDX_W-1:0] base,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    logic [IDX_W-1:0] pos;
    found = 1'b0;
    idx   = '0;
    pos   = '0;
    // walk from youngest to oldest age; the last match is the oldest
    for (int a = DEPTH - 1; a >= 0; a--) begin
      pos = base + IDX_W'(a);
      if (mask[pos]) begin
        found = 1'b1;
        idx   = pos;
      end
    end
  end

  assert_pick_in_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> mask[idx]);
  assert_pick_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (mask == '0));
endmodule

// File: rtl/lq_snoop_order.sv
module lq_snoop_order #(
  parameter int DEPTH      = 8,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_valid,
  output logic                     alloc_ready,
  output logic [$clog2(DEPTH)-1:0] alloc_idx,
  input  logic                     resolve_valid,
  input  logic [$clog2(DEPTH)-1:0] resolve_idx,
  input  logic [ADDR_W-1:0]        resolve_addr,
  input  logic                     resp_valid,
  input  logic [$clog2(DEPTH)-1:0] resp_idx,
  input  logic                     resp_inval,
  input  logic                     snoop_valid,
  input  logic [ADDR_W-1:0]        snoop_addr,
  output logic                     retire_valid,
  input  logic                     retire_ready,
  output logic [$clog2(DEPTH)-1:0] retire_idx,
  output logic                     squash_valid,
  output logic [$clog2(DEPTH)-1:0] squash_idx,
  output logic                     wb_valid,
  output logic [$clog2(DEPTH)-1:0] wb_idx
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [IDX_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  count_q;
  logic              wb_valid_q;
  logic [IDX_W-1:0]  wb_idx_q;

  logic [LINE_W-1:0] resolve_line, snoop_line;
  logic              addr_off_unused;
  logic [DEPTH-1:0]  alloc_en, drop_en, resp_en, resolve_en, older_res;
  logic [DEPTH-1:0]  ent_valid, ent_done, ent_fault, wb_clean;
  logic [IDX_W-1:0]  age [DEPTH];
  logic [IDX_W-1:0]  res_age, sq_age;
  logic              alloc_fire, retire_fire;

  assign resolve_line    = resolve_addr[ADDR_W-1:OFF_W];
  assign snoop_line      = snoop_addr[ADDR_W-1:OFF_W];
  assign addr_off_unused = ^{resolve_addr[OFF_W-1:0], snoop_addr[OFF_W-1:0]};

  // Oldest faulted slot
  lq_oldest_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .mask  (ent_fault),
    .base  (head_q),
    .found (squash_valid),
    .idx   (squash_idx)
  );

  assign res_age = resolve_idx - head_q;
  assign sq_age  = squash_idx - head_q;

  assign alloc_ready  = (count_q < CNT_W'(DEPTH)) && !squash_valid;
  assign alloc_fire   = alloc_valid && alloc_ready;
  assign alloc_idx    = tail_q;
  assign retire_idx   = head_q;
  assign retire_valid = ent_valid[head_q] && ent_done[head_q] && !ent_fault[head_q];
  assign retire_fire  = retire_valid && retire_ready;

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    assign age[j]        = IDX_W'(j) - head_q;
    assign alloc_en[j]   = alloc_fire && (tail_q == IDX_W'(j));
    assign resp_en[j]    = resp_valid && (resp_idx == IDX_W'(j));
    assign resolve_en[j] = resolve_valid && (resolve_idx == IDX_W'(j));
    assign older_res[j]  = resolve_valid && (age[j] > res_age);
    assign drop_en[j]    = (squash_valid && (age[j] >= sq_age)) ||
                           (retire_fire && (head_q == IDX_W'(j)));

    lq_entry #(.LINE_W(LINE_W)) u_ent (
      .clk           (clk),
      .rst_n         (rst_n),
      .alloc_en      (alloc_en[j]),
      .drop_en       (drop_en[j]),
      .snoop_valid   (snoop_valid),
      .snoop_line    (snoop_line),
      .resp_en       (resp_en[j]),
      .resp_inval    (resp_inval),
      .resolve_en    (resolve_en[j]),
      .older_resolve (older_res[j]),
      .resolve_line  (resolve_line),
      .valid_o       (ent_valid[j]),
      .done_o        (ent_done[j]),
      .fault_o       (ent_fault[j]),
      .wb_clean_o    (wb_clean[j])
    );
  end

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] x);
    return (x == IDX_W'(DEPTH - 1)) ? '0 : x + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q     <= '0;
      tail_q     <= '0;
      count_q    <= '0;
      wb_valid_q <= 1'b0;
      wb_idx_q   <= '0;
    end else begin
      if (retire_fire) head_q <= bump(head_q);
      if (squash_valid) begin
        tail_q  <= squash_idx;
        count_q <= CNT_W'(sq_age) - CNT_W'(retire_fire);
      end else begin
        if (alloc_fire) tail_q <= bump(tail_q);
        count_q <= count_q + CNT_W'(alloc_fire) - CNT_W'(retire_fire);
      end
      wb_valid_q <= |wb_clean;
      wb_idx_q   <= resp_idx;
    end
  end

  assign wb_valid = wb_valid_q;
  assign wb_idx   = wb_idx_q;

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));
  assert_tail_rewind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> (tail_q == $past(squash_idx)));
  assert_wb_follows_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(resp_valid));
  assert_retire_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> (count_q != '0));
endmodule

// File: tb/lq_snoop_order_tb_top.sv
`timescale 1ns/1ps
module lq_snoop_order_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic        alloc_ready;
  logic [2:0]  alloc_idx;
  logic        resolve_valid = 1'b0;
  logic [2:0]  resolve_idx = '0;
  logic [31:0] resolve_addr = '0;
  logic        resp_valid = 1'b0;
  logic [2:0]  resp_idx = '0;
  logic        resp_inval = 1'b0;
  logic        snoop_valid = 1'b0;
  logic [31:0] snoop_addr = '0;
  logic        retire_valid;
  logic        retire_ready = 1'b0;
  logic [2:0]  retire_idx;
  logic        squash_valid;
  logic [2:0]  squash_idx;
  logic        wb_valid;
  logic [2:0]  wb_idx;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  lq_snoop_order dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .resolve_valid(resolve_valid), .resolve_idx(resolve_idx), .resolve_addr(resolve_addr),
    .resp_valid(resp_valid), .resp_idx(resp_idx), .resp_inval(resp_inval),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .retire_valid(retire_valid), .retire_ready(retire_ready), .retire_idx(retire_idx),
    .squash_valid(squash_valid), .squash_idx(squash_idx),
    .wb_valid(wb_valid), .wb_idx(wb_idx)
  );

  typedef struct packed {
    logic        alloc;
    logic        rv;
    logic [2:0]  ri;
    logic [31:0] ra;
    logic        pv;
    logic [2:0]  pi;
    logic        pinv;
    logic        sv;
    logic [31:0] sa;
    logic        rr;
    logic        e_rdy;
    logic [2:0]  e_aidx;
    logic        e_sq;
    logic [2:0]  e_sqi;
    logic        e_wb;
    logic        e_ret;
  } vec_t;

  // Younger load issues first, older resolves to the same line, then the
  // younger load's response carries an invalidate.
  localparam vec_t VEC [9] = '{
    '{1'b1, 1'b0, 3'd0, 32'h0,    1'b0, 3'd0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 3'd0, 32'h0,    1'b0, 3'd0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 3'd1, 1'b0, 3'd0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 3'd1, 32'h1000, 1'b0, 3'd0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 3'd0, 32'h1010, 1'b0, 3'd0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 3'd0, 32'h0,    1'b1, 3'd1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 3'd0, 32'h0,    1'b0, 3'd0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 3'd2, 1'b1, 3'd1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 3'd0, 32'h0,    1'b1, 3'd0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 3'd1, 1'b0, 3'd0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 3'd0, 32'h0,    1'b0, 3'd0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 3'd1, 1'b0, 3'd0, 1'b1, 1'b1},
    '{1'b0, 1'b0, 3'd0, 32'h0,    1'b0, 3'd0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 3'd1, 1'b0, 3'd0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = 1'b0; resolve_valid = 1'b0; resp_valid = 1'b0;
    resp_inval = 1'b0; snoop_valid = 1'b0; retire_ready = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic alloc1();
    alloc_valid = 1'b1; tick();
  endtask

  task automatic resolve1(input logic [2:0] i, input logic [31:0] a);
    resolve_valid = 1'b1; resolve_idx = i; resolve_addr = a; tick();
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // reset state (R1, R9, R8, R11)
    #1;
    chk("R1 reset alloc_ready", int'(alloc_ready), 1);
    chk("R1 reset alloc_idx", int'(alloc_idx), 0);
    chk("R8 reset squash_valid", int'(squash_valid), 0);
    chk("R11 reset wb_valid", int'(wb_valid), 0);
    chk("R9 reset retire_valid", int'(retire_valid), 0);

    // Vector walk: R3 R5 R8 R11 R9
    for (int r = 0; r < 9; r++) begin
      alloc_valid = VEC[r].alloc;
      resolve_valid = VEC[r].rv; resolve_idx = VEC[r].ri; resolve_addr = VEC[r].ra;
      resp_valid = VEC[r].pv; resp_idx = VEC[r].pi; resp_inval = VEC[r].pinv;
      snoop_valid = VEC[r].sv; snoop_addr = VEC[r].sa;
      retire_ready = VEC[r].rr;
      #1;
      chk($sformatf("R1 row%0d alloc_ready", r), int'(alloc_ready), int'(VEC[r].e_rdy));
      chk($sformatf("R1 R8 row%0d alloc_idx", r), int'(alloc_idx), int'(VEC[r].e_aidx));
      chk($sformatf("R3 R5 row%0d squash_valid", r), int'(squash_valid), int'(VEC[r].e_sq));
      if (VEC[r].e_sq)
        chk($sformatf("R8 row%0d squash_idx", r), int'(squash_idx), int'(VEC[r].e_sqi));
      chk($sformatf("R11 row%0d wb_valid", r), int'(wb_valid), int'(VEC[r].e_wb));
      chk($sformatf("R9 row%0d retire_valid", r), int'(retire_valid), int'(VEC[r].e_ret));
      tick();
    end

    // R6 and R4: snoop before the older load resolves
    do_reset();
    alloc1(); alloc1();
    resolve1(3'd1, 32'h2040);
    snoop_valid = 1'b1; snoop_addr = 32'h2070; tick();
    resp_valid = 1'b1; resp_idx = 3'd1;
    #1 chk("R4 snoop without hazard no squash", int'(squash_valid), 0);
    tick();
    resolve_valid = 1'b1; resolve_idx = 3'd0; resolve_addr = 32'h2044;
    #1 chk("R11 clean wb_valid", int'(wb_valid), 1);
    chk("R11 clean wb_idx", int'(wb_idx), 1);
    tick();
    #1 chk("R6 late older resolve squash_valid", int'(squash_valid), 1);
    chk("R6 late older resolve squash_idx", int'(squash_idx), 1);
    tick();

    // R2: neighbouring line does not mark a hazard
    do_reset();
    alloc1(); alloc1();
    resolve1(3'd1, 32'h3000);
    resolve1(3'd0, 32'h3040);
    snoop_valid = 1'b1; snoop_addr = 32'h3000; tick();
    #1 chk("R2 different line no squash", int'(squash_valid), 0);
    tick();

    // R10 and R7: snoop and response together on a hazard slot
    do_reset();
    alloc1(); alloc1();
    resolve1(3'd1, 32'h4000);
    resolve1(3'd0, 32'h4008);
    snoop_valid = 1'b1; snoop_addr = 32'h4000;
    resp_valid = 1'b1; resp_idx = 3'd1; resp_inval = 1'b0;
    tick();
    resp_valid = 1'b1; resp_idx = 3'd1;
    #1 chk("R10 snoop applied before response wb_valid", int'(wb_valid), 0);
    chk("R4 hazard plus snoop squash_valid", int'(squash_valid), 1);
    chk("R4 squash_idx", int'(squash_idx), 1);
    chk("R1 alloc_ready low during squash", int'(alloc_ready), 0);
    tick();
    #1 chk("R7 response in squash cycle no wb", int'(wb_valid), 0);
    tick();

    // R8: two faulted slots, oldest reported
    do_reset();
    repeat (4) alloc1();
    resolve1(3'd3, 32'h5000);
    resolve1(3'd2, 32'h5000);
    resolve1(3'd1, 32'h5000);
    snoop_valid = 1'b1; snoop_addr = 32'h5020; tick();
    #1 chk("R8 multi squash_valid", int'(squash_valid), 1);
    chk("R8 multi oldest squash_idx", int'(squash_idx), 2);
    tick();
    #1 chk("R8 single squash pulse", int'(squash_valid), 0);
    chk("R8 tail rewound alloc_idx", int'(alloc_idx), 2);
    tick();

    // R1 full queue, R9 head-only retire and index wrap
    do_reset();
    repeat (8) alloc1();
    alloc_valid = 1'b1;
    #1 chk("R1 full alloc_ready", int'(alloc_ready), 0);
    chk("R1 full alloc_idx", int'(alloc_idx), 0);
    tick();
    resolve1(3'd1, 32'h6000);
    resp_valid = 1'b1; resp_idx = 3'd1; tick();
    retire_ready = 1'b1;
    #1 chk("R9 non-head done not retired", int'(retire_valid), 0);
    tick();
    resolve1(3'd0, 32'h7000);
    resp_valid = 1'b1; resp_idx = 3'd0; tick();
    retire_ready = 1'b1;
    #1 chk("R9 head retire_valid", int'(retire_valid), 1);
    chk("R9 head retire_idx", int'(retire_idx), 0);
    tick();
    #1 chk("R9 next head retire_valid", int'(retire_valid), 1);
    chk("R9 next head retire_idx", int'(retire_idx), 1);
    chk("R1 slot freed alloc_ready", int'(alloc_ready), 1);
    chk("R1 wrapped alloc_idx", int'(alloc_idx), 0);
    tick();

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule